// File: doc/BRIEF.md
# Maskable Interrupt Request Collector

This block gathers nineteen interrupt request lines into a register of pending flags. A per-source enable mask gates those flags, and the result drives a single registered interrupt line to the processor. A flag is set by a low-to-high transition on its request line. It stays set until software writes a one to its position in a write-one-to-clear register. When a peripheral has several internal flags, its request line is the OR of those flags.

Software reaches the block through a small register port made of a byte address, a write strobe, write data and combinational read data. The port holds three words: the enable mask at offset 0x00, the clear word at offset 0x04 and the read-only pending word at offset 0x08. Bit 15 of the enable mask has two meanings, chosen by a static mode input. With the mode input low, bit 15 is a master gate over every source, and source 15 can never interrupt. With the mode input high, there is no master gate, and bit 15 is the ordinary enable for source 15, the external bus-ready request.

Top module: `irq_collector`

## Requirements
- R1: Offset 0x00 reads back the enable mask in bits 18:0. Offset 0x08 reads the pending flags in bits 18:0. Offset 0x04 and any other offset read as zero, and bits 31:19 of every read are zero.
- R2: Request input bit k maps to pending bit k and enable bit k, for k from 0 to 18. The sources are: bits 0-3 external requests, 4 audio receive, 5 audio transmit, 6 timer, 7 serial port, 8 USB device, 9 general serial port, 10 USB host, 11 disc interface, 12 display, 13 DMA, 14 wide timer, 15 bus-ready, 16 ADC, 17 I2C, 18 camera.
- R3: A pending flag is set by the clock edge at which its request input is high and was low at the previous edge. It is visible on a read right after that edge. A request that stays high does not set the flag again.
- R4: A write to offset 0x04 clears every pending flag whose data bit is 1 and leaves every other flag unchanged.
- R5: When a clear and a new rising request hit the same bit at the same edge, the flag is left set.
- R6: Writes to offset 0x08 have no effect on the pending flags or on the enable mask.
- R7: A pending source whose enable bit is 0 never causes an interrupt.
- R8: With the mode input at 0, enable bit 15 is a master gate: with it at 0 the interrupt output stays 0, and pending source 15 never contributes.
- R9: With the mode input at 1, there is no master gate, and enable bit 15 enables source 15 like any other bit.
- R10: The interrupt output is a register. It is 1 exactly one edge after an edge that leaves some flag both pending and effectively enabled.
- R11: An asynchronous active-low reset clears the enable mask, the pending flags, the edge history and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 19 | Source request levels |
| rdy_mode_i | input | 1 | 0: bit 15 is master gate; 1: bit 15 enables source 15 |
| bus_addr_i | input | 4 | Byte offset into the register window |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset |
| cpu_irq_o | output | 1 | Registered interrupt to the processor |

## Verification
A corrupt pending flag shows on a read of offset 0x08 in the same cycle. One edge later it shows on the interrupt line whenever that source is enabled. A wrong enable mask shows at once on a read of offset 0x00. A wrong treatment of bit 15 only shows on the interrupt line, one edge after the mask or mode changes. For that reason the bench compares the line against its model on every cycle, in both modes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned NUM_SRC  = 19;
  parameter int unsigned BUS_DW   = 32;
  parameter int unsigned BUS_AW   = 4;
  parameter int unsigned GATE_BIT = 15;
  parameter logic [7:0]  OFS_MASK = 8'h00;
  parameter logic [7:0]  OFS_CLR  = 8'h04;
  parameter logic [7:0]  OFS_PEND = 8'h08;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] set_w;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  assign set_w = req_i & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    logic upd;
    assign upd       = set_w[k] | clr_i[k];
    assign pend_d[k] = set_w[k] ? 1'b1 : 1'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q[k] <= 1'b0;
      else if (upd) pend_q[k] <= pend_d[k];
    end
  end

  assign pend_o = pend_q;

  // R3
  new_flag_has_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_w)) == '0));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((pend_q & $past(set_w)) == $past(set_w)));
  // R4
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_w) != '0) |=> ((pend_q & $past(clr_i & ~set_w)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  parameter int unsigned DW   = irq_pkg::BUS_DW,
  parameter int unsigned AW   = irq_pkg::BUS_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [AW-1:0] A_MASK = irq_pkg::OFS_MASK[AW-1:0];
  localparam logic [AW-1:0] A_CLR  = irq_pkg::OFS_CLR[AW-1:0];
  localparam logic [AW-1:0] A_PEND = irq_pkg::OFS_PEND[AW-1:0];
  localparam int unsigned   PADW   = DW - NSRC;

  logic            sel_mask, sel_clr, sel_pend;
  logic            mask_we;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mask_d;
  logic [DW-1:0]   unused_wdata;

  assign sel_mask     = (addr_i == A_MASK);
  assign sel_clr      = (addr_i == A_CLR);
  assign sel_pend     = (addr_i == A_PEND);
  assign mask_we      = wr_i & sel_mask;
  assign mask_d       = wdata_i[NSRC-1:0];
  assign unused_wdata = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_comb begin
    clr_o = '0;
    if (wr_i && sel_clr) clr_o = wdata_i[NSRC-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_mask)      rdata_o = {{PADW{1'b0}}, mask_q};
    else if (sel_pend) rdata_o = {{PADW{1'b0}}, pend_i};
  end

  assign mask_o = mask_q;

  // R1
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_mask) |=> (mask_q == $past(wdata_i[NSRC-1:0])));
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel_mask) |=> $stable(mask_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NSRC  = irq_pkg::NUM_SRC,
  parameter int unsigned GBIT  = irq_pkg::GATE_BIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            rdy_mode_i,
  output logic            irq_o
);
  logic [NSRC-1:0] eff_mask;
  logic            master_ok;
  logic            irq_d;
  logic            irq_q;

  always_comb begin
    eff_mask       = mask_i;
    eff_mask[GBIT] = mask_i[GBIT] & rdy_mode_i;
    master_ok      = rdy_mode_i | mask_i[GBIT];
    irq_d          = master_ok & (|(pend_i & eff_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_mode_i && !mask_i[GBIT]) |=> !irq_q);
  // R7
  nothing_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & mask_i) == '0) |=> !irq_q);
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  parameter int unsigned DW   = irq_pkg::BUS_DW,
  parameter int unsigned AW   = irq_pkg::BUS_AW,
  parameter int unsigned GBIT = irq_pkg::GATE_BIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            rdy_mode_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_wr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            cpu_irq_o
);
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] mask_w;
  logic [NSRC-1:0] clr_w;

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_w), .pend_o(pend_w)
  );

  irq_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .pend_i(pend_w), .mask_o(mask_w),
    .clr_o(clr_w), .rdata_o(bus_rdata_o)
  );

  irq_gate #(.NSRC(NSRC), .GBIT(GBIT)) u_gate (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .mask_i(mask_w),
    .rdy_mode_i(rdy_mode_i), .irq_o(cpu_irq_o)
  );

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DW-1:NSRC] == '0);
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int N = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] req = '0;
  logic        mode = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [18:0] m_pend, m_mask, m_req;
  logic        m_irq;

  irq_collector u_irq_collector (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rdy_mode_i(mode),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  always #2 clk = ~clk;

  function automatic logic f_irq(logic [18:0] p, logic [18:0] m, logic md);
    logic [18:0] e;
    e = m;
    if (!md) e[15] = 1'b0;
    return (md | m[15]) & (|(p & e));
  endfunction

  function automatic logic [31:0] f_read(logic [3:0] a);
    if (a == 4'h0) return {13'b0, m_mask};
    if (a == 4'h8) return {13'b0, m_pend};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_mask <= '0; m_req <= '0; m_irq <= 1'b0;
    end else begin
      logic [18:0] clr;
      clr = (wr && addr == 4'h4) ? wdata[18:0] : '0;
      m_irq  <= f_irq(m_pend, m_mask, mode);
      m_pend <= (m_pend & ~clr) | (req & ~m_req);
      m_req  <= req;
      if (wr && addr == 4'h0) m_mask <= wdata[18:0];
    end
  end

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [18:0] r, logic md, logic w, logic [3:0] a,
                     logic [31:0] d, string tag);
    @(negedge clk);
    chk(irq == m_irq, {tag, " R10 irq"}, {31'b0, irq}, {31'b0, m_irq});
    req = r; mode = md; wr = w; addr = a; wdata = d;
    #1;
    chk(rdata == f_read(a), {tag, " R1 read"}, rdata, f_read(a));
  endtask

  task automatic peek(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    #1;
    chk(irq == 1'b0, "R11 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    peek(4'h0, 32'h0, "R11 mask after reset");
    peek(4'h8, 32'h0, "R11 pend after reset");

    // R1 reserved bits and R2 mapping
    cyc('0, 0, 1, 4'h0, 32'hFFFF_FFFF, "R1 write all ones");
    peek(4'h0, 32'h0007_FFFF, "R1 reserved zero");
    cyc(19'h00008, 0, 0, 4'h8, 0, "R2 src3 rise");
    peek(4'h8, 32'h0000_0008, "R2 R3 src3 pending");
    @(negedge clk); #1;
    chk(irq == 1'b1, "R10 irq from src3", {31'b0, irq}, 32'h1);
    // R7 mask src3
    cyc(19'h00008, 0, 1, 4'h0, 32'h0007_FFF7, "R7 mask src3");
    cyc(19'h00008, 0, 0, 4'h8, 0, "R7 settle");
    cyc(19'h00008, 0, 0, 4'h8, 0, "R7 settle2");
    chk(irq == 1'b0, "R7 masked no irq", {31'b0, irq}, 32'h0);
    // R8 master off
    cyc(19'h00008, 0, 1, 4'h0, 32'h0000_7FFF, "R8 master off");
    cyc(19'h00008, 0, 0, 4'h8, 0, "R8 settle");
    cyc(19'h00008, 0, 0, 4'h8, 0, "R8 settle2");
    chk(irq == 1'b0, "R8 gated", {31'b0, irq}, 32'h0);
    // R9 ready mode ignores master gate
    cyc(19'h00008, 1, 0, 4'h8, 0, "R9 mode1");
    cyc(19'h00008, 1, 0, 4'h8, 0, "R9 settle");
    chk(irq == 1'b1, "R9 no master gate", {31'b0, irq}, 32'h1);
    // R8 source 15 blocked in master mode
    cyc(19'h08000, 0, 1, 4'h4, 32'h0000_0008, "R4 clear src3, R8 src15 rise");
    cyc(19'h08000, 0, 1, 4'h0, 32'h0000_8000, "R8 only bit15");
    cyc(19'h08000, 0, 0, 4'h8, 0, "R8 settle");
    cyc(19'h08000, 0, 0, 4'h8, 0, "R8 settle2");
    chk(irq == 1'b0, "R8 src15 blocked", {31'b0, irq}, 32'h0);
    peek(4'h8, 32'h0000_8000, "R4 src3 cleared, src15 held");
    cyc(19'h08000, 1, 0, 4'h8, 0, "R9 src15 mode1");
    cyc(19'h08000, 1, 0, 4'h8, 0, "R9 settle");
    chk(irq == 1'b1, "R9 src15 enabled", {31'b0, irq}, 32'h1);
    // R5 set wins over clear
    cyc(19'h00000, 1, 0, 4'h8, 0, "R5 prep low");
    cyc(19'h00001, 1, 1, 4'h4, 32'h0000_0001, "R5 set+clear");
    peek(4'h8, 32'h0000_8001, "R5 set wins");
    // R3 held level does not re-set
    cyc(19'h00001, 1, 1, 4'h4, 32'h0000_0001, "R3 clear held");
    peek(4'h8, 32'h0000_8000, "R3 no reset from level");
    // R6 write to pending is ignored
    cyc(19'h00001, 1, 1, 4'h8, 32'hFFFF_FFFF, "R6 write pend");
    peek(4'h8, 32'h0000_8000, "R6 pend unchanged");
    peek(4'h0, 32'h0000_8000, "R6 mask unchanged");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic [18:0] r;
      case ($urandom % 4)
        0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; default: a = 4'hC;
      endcase
      r = req ^ (19'($urandom) & 19'($urandom) & 19'($urandom));
      cyc(r, (i % 200) < 100, ($urandom % 3) == 0, a, $urandom, "R2 R3 R4 rand");
    end
    @(negedge clk);
    chk(irq == m_irq, "R10 final irq", {31'b0, irq}, {31'b0, m_irq});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule